// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM's contents alive. A free-running interval counter raises a pending-refresh flag, and the sequencer issues an AUTO REFRESH command whenever the host access path is idle. On request it also places the device into self-refresh and brings it back out. The block drives one-cycle command strobes (precharge-all, auto refresh, self-refresh entry, self-refresh exit), the clock-enable pin and an enable for the SDRAM clock. A two-word configuration interface holds the refresh interval, a minimum self-refresh dwell, the self-refresh request, a clock keep-alive option, a read-only status flag, and one shared wait count that serves as tRC, tRFC and tXSR.

The host raises `host_req` while it wants to access the device or is doing so. The sequencer never starts a command while `host_req` is high. It answers with `host_gnt` only when it is idle and has no work pending. The controller has five states. ST_IDLE goes to ST_TRFC on AUTO REFRESH, or to ST_TRC on PRECHARGE-ALL. ST_TRFC returns to ST_IDLE when its wait ends. ST_TRC goes to ST_SELF when its wait ends, issuing SELF-REFRESH ENTRY. ST_SELF goes to ST_TXSR, issuing SELF-REFRESH EXIT, once the request is cleared and the dwell has elapsed. ST_TXSR returns to ST_IDLE when its wait ends and sets the status flag.

Top module: `sdram_rfsh_seq`

## Requirements
- R1: After reset, the refresh word (`cfg_sel`=0) reads 0x1007F08C and the timing word (`cfg_sel`=1) reads 0x0000000E. The refresh word holds the interval in [11:0], the dwell in [18:12], the self-refresh request in [24], the clock keep-alive in [25] and the status in [28]. The timing word holds the wait field N in [3:0]. Every other bit reads zero.
- R2: With the host idle and interval I, `cmd_aref` pulses once every I+1 cycles.
- R3: No command strobe rises while `host_req` is high. A refresh that became pending during that time is issued in the cycle after `host_req` falls.
- R4: After `cmd_aref`, no command and no grant follow for N+1 cycles. With `host_req` high, `host_gnt` rises N+1 cycles after the strobe.
- R5: `host_gnt` is high only while `host_req` is high, `sdram_cke` is high and no strobe is active.
- R6: Self-refresh entry issues `cmd_pall` first. `cmd_srent` follows N+1 cycles later. `sdram_cke` and the status flag both go low in the `cmd_srent` cycle.
- R7: In self-refresh, `sdram_clk_en` equals the keep-alive bit. In all other states it is high.
- R8: Exit cannot begin until D+1 cycles after `cmd_srent`, where D is the dwell field.
- R9: After the request bit is cleared, `cmd_srext` pulses with `sdram_cke` and `sdram_clk_en` high. The status flag returns to 1 N+1 cycles later.
- R10: The interval counter restarts from its reload on exit. The first `cmd_aref` comes I+2 cycles after the status flag rises.
- R11: If a refresh is pending when self-refresh is requested, `cmd_aref` is issued first, and `cmd_pall` follows N+2 cycles later.
- R12: Writes do not change the status bit.
- R13: Each strobe lasts exactly one cycle, and at most one strobe is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 refresh word, 1 timing word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected word read-back |
| host_req | input | 1 | Host wants or holds the SDRAM |
| host_gnt | output | 1 | Host may access the SDRAM |
| cmd_pall | output | 1 | PRECHARGE-ALL strobe |
| cmd_aref | output | 1 | AUTO REFRESH strobe |
| cmd_srent | output | 1 | SELF-REFRESH ENTRY strobe |
| cmd_srext | output | 1 | SELF-REFRESH EXIT strobe |
| sdram_cke | output | 1 | SDRAM clock enable pin |
| sdram_clk_en | output | 1 | Enable for the SDRAM clock |

## Verification
The assertions check several properties on every cycle. They confirm that the strobes are exclusive and single-cycle, that a grant coincides with neither a command nor a low CKE, and that CKE edges occur only with the entry and exit strobes. They also confirm that the clock is stopped only while CKE is low, that the status flag falls only on entry, and that a refresh follows a cycle in which the host was idle. The exact cycle distances are shown only by the bench's directed scenarios. These are the refresh period, the tRC, tRFC and tXSR waits, the dwell, the restart of the interval after exit, and the ordering of a pending refresh ahead of entry. Randomized configuration writes cover the read-back layout and the read-only status bit.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRFC,
        ST_TRC,
        ST_SELF,
        ST_TXSR
    } rfsh_state_e;

    localparam int IVL_LSB   = 0;
    localparam int DWELL_LSB = 12;
    localparam int EN_BIT    = 24;
    localparam int KEEP_BIT  = 25;
    localparam int STAT_BIT  = 28;
endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
    import sdram_rfsh_pkg::*;
#(
    parameter int DW        = 32,
    parameter int IVL_W     = 12,
    parameter int DWELL_W   = 7,
    parameter int WAIT_W    = 4,
    parameter logic [IVL_W-1:0]   IVL_RST   = 12'h08c,
    parameter logic [DWELL_W-1:0] DWELL_RST = 7'h7f,
    parameter logic [WAIT_W-1:0]  WAIT_RST  = 4'he
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               sel,
    input  logic [DW-1:0]      wdata,
    input  logic               status,
    output logic [DW-1:0]      rdata,
    output logic [IVL_W-1:0]   ivl,
    output logic [DWELL_W-1:0] dwell,
    output logic               sr_en,
    output logic               keep_clk,
    output logic [WAIT_W-1:0]  twait
);
    logic wdata_unused;
    assign wdata_unused = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl      <= IVL_RST;
            dwell    <= DWELL_RST;
            sr_en    <= 1'b0;
            keep_clk <= 1'b0;
            twait    <= WAIT_RST;
        end else if (we) begin
            if (!sel) begin
                ivl      <= wdata[IVL_LSB +: IVL_W];
                dwell    <= wdata[DWELL_LSB +: DWELL_W];
                sr_en    <= wdata[EN_BIT];
                keep_clk <= wdata[KEEP_BIT];
            end else begin
                twait    <= wdata[WAIT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[IVL_LSB +: IVL_W]     = ivl;
            rdata[DWELL_LSB +: DWELL_W] = dwell;
            rdata[EN_BIT]               = sr_en;
            rdata[KEEP_BIT]             = keep_clk;
            rdata[STAT_BIT]             = status;
        end else begin
            rdata[WAIT_W-1:0]           = twait;
        end
    end
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int W = 12,
    parameter logic [W-1:0] RST = 12'h08c
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload,
    input  logic         hold,
    input  logic         clr,
    output logic         pend
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= RST;
            pend <= 1'b0;
        end else if (hold) begin
            cnt  <= reload;
            pend <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= reload;
            pend <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rfsh_down_timer.sv
module rfsh_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_rfsh_seq.sv
module sdram_rfsh_seq
    import sdram_rfsh_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IVL_W   = 12,
    parameter int DWELL_W = 7,
    parameter int WAIT_W  = 4,
    parameter logic [IVL_W-1:0]   IVL_RST   = 12'h08c,
    parameter logic [DWELL_W-1:0] DWELL_RST = 7'h7f,
    parameter logic [WAIT_W-1:0]  WAIT_RST  = 4'he
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          host_req,
    output logic          host_gnt,
    output logic          cmd_pall,
    output logic          cmd_aref,
    output logic          cmd_srent,
    output logic          cmd_srext,
    output logic          sdram_cke,
    output logic          sdram_clk_en
);
    rfsh_state_e state, nxt;

    logic [IVL_W-1:0]   ivl;
    logic [DWELL_W-1:0] dwell;
    logic [WAIT_W-1:0]  twait;
    logic sr_en, keep_clk, status_q, pend;
    logic wait_done, dwell_done;
    logic ld_wait, ld_dwell, set_stat;
    logic do_aref, do_pall, do_srent, do_srext;
    logic in_sr;

    rfsh_cfg_regs #(
        .DW(DW), .IVL_W(IVL_W), .DWELL_W(DWELL_W), .WAIT_W(WAIT_W),
        .IVL_RST(IVL_RST), .DWELL_RST(DWELL_RST), .WAIT_RST(WAIT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .status(status_q), .rdata(cfg_rdata),
        .ivl(ivl), .dwell(dwell), .sr_en(sr_en), .keep_clk(keep_clk),
        .twait(twait)
    );

    assign in_sr = (state == ST_SELF) || (state == ST_TXSR);

    rfsh_interval_timer #(.W(IVL_W), .RST(IVL_RST)) u_ivl (
        .clk(clk), .rst_n(rst_n), .reload(ivl), .hold(in_sr),
        .clr(do_aref), .pend(pend)
    );

    rfsh_down_timer #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(ld_wait), .val(twait),
        .done(wait_done)
    );

    rfsh_down_timer #(.W(DWELL_W)) u_dwell (
        .clk(clk), .rst_n(rst_n), .load(ld_dwell), .val(dwell),
        .done(dwell_done)
    );

    always_comb begin
        nxt      = state;
        ld_wait  = 1'b0;
        ld_dwell = 1'b0;
        set_stat = 1'b0;
        do_aref  = 1'b0;
        do_pall  = 1'b0;
        do_srent = 1'b0;
        do_srext = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pend && !host_req) begin
                    nxt     = ST_TRFC;
                    ld_wait = 1'b1;
                    do_aref = 1'b1;
                end else if (sr_en && !host_req) begin
                    nxt     = ST_TRC;
                    ld_wait = 1'b1;
                    do_pall = 1'b1;
                end
            end
            ST_TRFC: if (wait_done) nxt = ST_IDLE;
            ST_TRC: begin
                if (wait_done) begin
                    nxt      = ST_SELF;
                    ld_dwell = 1'b1;
                    do_srent = 1'b1;
                end
            end
            ST_SELF: begin
                if (!sr_en && dwell_done) begin
                    nxt      = ST_TXSR;
                    ld_wait  = 1'b1;
                    do_srext = 1'b1;
                end
            end
            ST_TXSR: begin
                if (wait_done) begin
                    nxt      = ST_IDLE;
                    set_stat = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_pall     <= 1'b0;
            cmd_aref     <= 1'b0;
            cmd_srent    <= 1'b0;
            cmd_srext    <= 1'b0;
            sdram_cke    <= 1'b1;
            sdram_clk_en <= 1'b1;
            status_q     <= 1'b1;
        end else begin
            cmd_pall     <= do_pall;
            cmd_aref     <= do_aref;
            cmd_srent    <= do_srent;
            cmd_srext    <= do_srext;
            sdram_cke    <= (nxt != ST_SELF);
            sdram_clk_en <= (nxt == ST_SELF) ? keep_clk : 1'b1;
            if (do_srent)      status_q <= 1'b0;
            else if (set_stat) status_q <= 1'b1;
        end
    end

    assign host_gnt = host_req && (state == ST_IDLE) && !pend && !sr_en;
endmodule

// File: rtl/sdram_rfsh_seq_chk.sv
module sdram_rfsh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic host_req,
    input logic host_gnt,
    input logic cmd_pall,
    input logic cmd_aref,
    input logic cmd_srent,
    input logic cmd_srext,
    input logic sdram_cke,
    input logic sdram_clk_en,
    input logic status
);
    logic any_cmd;
    assign any_cmd = cmd_pall | cmd_aref | cmd_srent | cmd_srext;

    assert_one_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pall, cmd_aref, cmd_srent, cmd_srext}));

    assert_aref_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_aref |=> !cmd_aref);

    assert_pall_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pall |=> !cmd_pall);

    assert_gnt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> (host_req && sdram_cke && !any_cmd));

    assert_cke_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdram_cke) |-> cmd_srent);

    assert_status_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status) |-> cmd_srent);

    assert_cke_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdram_cke) |-> (cmd_srext && sdram_clk_en));

    assert_clk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sdram_clk_en |-> !sdram_cke);

    assert_aref_host_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_aref |-> !$past(host_req));
endmodule

bind sdram_rfsh_seq sdram_rfsh_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_gnt(host_gnt),
    .cmd_pall(cmd_pall), .cmd_aref(cmd_aref), .cmd_srent(cmd_srent),
    .cmd_srext(cmd_srext), .sdram_cke(sdram_cke),
    .sdram_clk_en(sdram_clk_en), .status(status_q)
);

// File: tb/sdram_rfsh_seq_test.sv
`timescale 1ns/100ps
module sdram_rfsh_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        host_req = 1'b0;
    logic        host_gnt;
    logic        cmd_pall, cmd_aref, cmd_srent, cmd_srext;
    logic        sdram_cke, sdram_clk_en;

    int n_tests = 0;
    int n_fail  = 0;
    int strobe_bad = 0;
    bit done_flag = 1'b0;

    localparam int NW = 3;
    localparam int IV = 20;

    always #2.5 clk = ~clk;

    sdram_rfsh_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_req(host_req),
        .host_gnt(host_gnt), .cmd_pall(cmd_pall), .cmd_aref(cmd_aref),
        .cmd_srent(cmd_srent), .cmd_srext(cmd_srext), .sdram_cke(sdram_cke),
        .sdram_clk_en(sdram_clk_en)
    );

    function automatic logic [31:0] exp_ref(input logic [31:0] d, input logic st);
        return (d & 32'h0307_FFFF) | ({31'd0, st} << 28);
    endfunction

    function automatic logic [31:0] exp_tim(input logic [31:0] d);
        return d & 32'h0000_000F;
    endfunction

    function automatic logic [31:0] ref_word(input int iv, input int dw,
                                             input bit en, input bit keep);
        return iv[11:0] | (32'(dw[6:0]) << 12) | (32'(en) << 24) | (32'(keep) << 25);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 1'b0;
    endtask

    function automatic logic pick(input int w);
        case (w)
            0: return cmd_aref;
            1: return cmd_pall;
            2: return cmd_srent;
            3: return cmd_srext;
            4: return host_gnt;
            default: return cfg_rdata[28];
        endcase
    endfunction

    task automatic count_until(input int w, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pick(w) && n < 2000);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(negedge clk) begin : strobe_mon
        logic [3:0] prev;
        logic [3:0] cur;
        cur = {cmd_pall, cmd_aref, cmd_srent, cmd_srext};
        if (rst_n) begin
            if ($countones(cur) > 1) strobe_bad++;
            if ((cur & prev) != 4'b0) strobe_bad++;
        end
        prev = cur;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin : main
        int n, n2;
        int bad;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        #1;
        chk("R1 refresh word reset", cfg_rdata, 32'h1007_F08C);
        cfg_sel = 1'b1; #1;
        chk("R1 timing word reset", cfg_rdata, 32'h0000_000E);
        cfg_sel = 1'b0;
        chk("R7 clk_en after reset", {31'd0, sdram_clk_en}, 32'd1);
        chk("R6 cke after reset", {31'd0, sdram_cke}, 32'd1);
        @(negedge clk);

        // R1/R12 randomized write/readback, request bit kept low
        for (int i = 0; i < 16; i++) begin
            d = $urandom() & ~(32'h1 << 24);
            wr(1'b0, d); #1;
            chk("R1 refresh readback / R12 status kept", cfg_rdata, exp_ref(d, 1'b1));
            d = $urandom();
            wr(1'b1, d);
            cfg_sel = 1'b1; #1;
            chk("R1 timing readback", cfg_rdata, exp_tim(d));
            cfg_sel = 1'b0;
        end

        // Known configuration
        wr(1'b1, NW);
        wr(1'b0, ref_word(IV, 5, 1'b0, 1'b0));

        // R2 refresh period
        count_until(0, n);
        count_until(0, n);
        count_until(0, n);
        chk("R2 refresh period", n, IV + 1);

        // R4 refresh blocks grant for N+1 cycles
        host_req = 1'b1;
        bad = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (cmd_pall | cmd_aref | cmd_srent | cmd_srext) bad++;
        end while (!host_gnt && n < 2000);
        chk("R4 grant after tRFC", n, NW + 1);
        chk("R4 no command during tRFC", bad, 0);
        chk("R5 grant while idle", {31'd0, host_gnt}, 32'd1);

        // R3 host busy defers refresh
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cmd_pall | cmd_aref | cmd_srent | cmd_srext) bad++;
        end
        chk("R3 no command while host busy", bad, 0);
        chk("R5 no grant with refresh pending", {31'd0, host_gnt}, 32'd0);
        host_req = 1'b0;
        count_until(0, n);
        chk("R3 refresh right after release", n, 1);

        // R11 pending refresh served before entry
        repeat (10) @(negedge clk);
        host_req = 1'b1;
        repeat (40) @(negedge clk);
        wr(1'b0, ref_word(IV, 5, 1'b1, 1'b0));
        host_req = 1'b0;
        count_until(0, n);
        chk("R11 pending refresh first", n, 1);
        count_until(1, n);
        chk("R11 precharge after refresh", n, NW + 2);

        // R6 entry
        count_until(2, n);
        chk("R6 entry after tRC", n, NW + 1);
        chk("R6 cke low on entry", {31'd0, sdram_cke}, 32'd0);
        #1;
        chk("R6 status low on entry", {31'd0, cfg_rdata[28]}, 32'd0);
        chk("R7 clock stopped, keep=0", {31'd0, sdram_clk_en}, 32'd0);

        // stay in self-refresh: no refresh commands
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cmd_pall | cmd_aref | cmd_srent | cmd_srext) bad++;
        end
        chk("R10 no refresh in self-refresh", bad, 0);
        chk("R6 cke held low", {31'd0, sdram_cke}, 32'd0);

        // R12 write of status bit ignored; R7 keep-alive on
        wr(1'b0, ref_word(IV, 5, 1'b1, 1'b1) | (32'h1 << 28));
        #1;
        chk("R12 status write ignored", {31'd0, cfg_rdata[28]}, 32'd0);
        @(negedge clk);
        chk("R7 clock kept, keep=1", {31'd0, sdram_clk_en}, 32'd1);
        chk("R7 cke still low", {31'd0, sdram_cke}, 32'd0);

        // R9 exit
        wr(1'b0, ref_word(IV, 5, 1'b0, 1'b1));
        @(negedge clk);
        chk("R9 exit strobe", {31'd0, cmd_srext}, 32'd1);
        chk("R9 cke high on exit", {31'd0, sdram_cke}, 32'd1);
        chk("R9 clock on at exit", {31'd0, sdram_clk_en}, 32'd1);
        #1;
        chk("R9 status still low", {31'd0, cfg_rdata[28]}, 32'd0);
        count_until(5, n);
        chk("R9 status after tXSR", n, NW + 1);

        // R10 interval restart
        count_until(0, n);
        chk("R10 first refresh after exit", n, IV + 2);

        // R8 dwell
        wr(1'b0, ref_word(IV, 30, 1'b1, 1'b0));
        count_until(1, n);
        count_until(2, n);
        chk("R6 entry after tRC (second)", n, NW + 1);
        wr(1'b0, ref_word(IV, 30, 1'b0, 1'b0));
        count_until(3, n2);
        chk("R8 dwell before exit", n2 + 1, 31);
        count_until(5, n);
        chk("R9 status after tXSR (second)", n, NW + 1);

        repeat (5) @(negedge clk);
        chk("R13 single-cycle exclusive strobes", strobe_bad, 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end
endmodule